// File: doc/BRIEF.md
# Card Socket Supervisor with Detect Debounce

This block watches a removable card socket. Two active-low card-detect lines are sampled once per slow tick (nominally every 10 ms). A new detect level is acted on only when two consecutive tick samples agree. If the agreed level shows either line high, the socket is treated as empty: the supervisor sets both status flags, cuts socket power, holds the card reset low and releases the data bus. If both lines are low, the card is present. Power and reset are then handed back to the card bring-up logic, and the "no card" flag clears. The "not initialized" flag stays set until the bring-up logic reports success with a one-cycle `init_done` pulse.

A small shared countdown timer runs off the same tick. Other logic loads it with a delay in ticks and then waits for its zero indication.

The supervisor is a three-state machine. `ST_EMPTY` means no card: the flags are set, power is off, reset is asserted and the bus is floated. `ST_AWAIT_INIT` means a card is present and powered, with reset released and the bus driven, but it is not yet initialized. `ST_READY` means a card is present and initialized. The transitions are:
- `T_INSERT`: `ST_EMPTY` to `ST_AWAIT_INIT` on a stable present sample.
- `T_INIT_OK`: `ST_AWAIT_INIT` to `ST_READY` on `init_done`.
- `T_REMOVE`: any state to `ST_EMPTY` on a stable empty sample.

Top module: `sock_supervisor`

## Requirements
- R1: The detect pair is sampled only on `tick`. A sample is acted on only when it equals the sample taken on the previous tick. Reset preloads the stored sample as both lines high. Any sample that differs from the one before it causes no change.
- R2: A stable sample with `cd_a_n` or `cd_b_n` high (1) counts as an empty socket.
- R3: An empty socket sets `flag_nodisk` and `flag_noinit` to 1 and drives `sock_pwr_en` to 0, `card_rst_n` to 0 and `bus_float` to 1.
- R4: A stable sample with both detect lines low (0) clears `flag_nodisk` and leaves `flag_noinit` at its present value. While a card is present, `sock_pwr_en` is 1, `card_rst_n` is 1 and `bus_float` is 0.
- R5: On each `tick` the timer value decrements by one while it is nonzero. Once at zero it holds at zero.
- R6: `flag_noinit` clears only on an `init_done` pulse, and only while `flag_nodisk` is 0. The pulse is ignored while the socket is empty.
- R7: After reset, `flag_nodisk`=1, `flag_noinit`=1, `sock_pwr_en`=0, `card_rst_n`=0, `bus_float`=1, the timer is 0 and `tmr_zero`=1.
- R8: `tmr_load` writes `tmr_value` into the timer on the next clock edge and takes priority over a simultaneous tick. `tmr_zero` is 1 exactly when the timer value is 0.
- R9: If a stable empty sample and an `init_done` pulse reach the state machine in the same cycle, removal wins. The block ends in the empty state with `flag_noinit`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every sampling period |
| cd_a_n | input | 1 | First card-detect line, low when seated |
| cd_b_n | input | 1 | Second card-detect line, low when seated |
| init_done | input | 1 | One-cycle pulse: card bring-up succeeded |
| tmr_load | input | 1 | Load the shared timer |
| tmr_value | input | TMR_W | Value to load into the timer |
| flag_nodisk | output | 1 | No card in the socket |
| flag_noinit | output | 1 | Card not initialized |
| sock_pwr_en | output | 1 | Socket power switch enable |
| card_rst_n | output | 1 | Card reset, active low |
| bus_float | output | 1 | Data bus drivers released |
| tmr_count | output | TMR_W | Current timer value |
| tmr_zero | output | 1 | Timer has reached zero |

## Verification
The hardest case to reach is the one where a removal event and an `init_done` pulse arrive at the state machine in the same cycle. The removal event comes out of the debouncer one cycle after the confirming tick. The stimulus therefore first inserts a card and leaves it uninitialized. It then presents an empty level for two ticks and raises `init_done` exactly one cycle after the second tick. Bounce is covered by alternating detect levels across ticks, so that no two consecutive samples match.

// File: rtl/sock_pkg.sv
package sock_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY      = 2'd0,
        ST_AWAIT_INIT = 2'd1,
        ST_READY      = 2'd2
    } sock_state_e;
endpackage

// File: rtl/sock_debounce.sv
module sock_debounce #(
    parameter int CD_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [CD_W-1:0] cd_n,
    output logic            ev_empty,
    output logic            ev_present
);
    logic [CD_W-1:0] last_q;
    logic            agree;

    assign agree = (cd_n == last_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q     <= '1;
            ev_empty   <= 1'b0;
            ev_present <= 1'b0;
        end else begin
            ev_empty   <= tick && agree && (|cd_n);
            ev_present <= tick && agree && (cd_n == '0);
            if (tick) last_q <= cd_n;
        end
    end

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_empty && ev_present)); // R1
    AST_EVT_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_empty || ev_present) |-> $past(tick)); // R1
endmodule

// File: rtl/sock_fsm.sv
module sock_fsm
    import sock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_empty,
    input  logic ev_present,
    input  logic init_done,
    output logic flag_nodisk,
    output logic flag_noinit,
    output logic sock_pwr_en,
    output logic card_rst_n,
    output logic bus_float
);
    sock_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (ev_present) state_d = ST_AWAIT_INIT;
            end
            ST_AWAIT_INIT: begin
                if (ev_empty)       state_d = ST_EMPTY;
                else if (init_done) state_d = ST_READY;
            end
            ST_READY: begin
                if (ev_empty) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        flag_nodisk = 1'b1;
        flag_noinit = 1'b1;
        sock_pwr_en = 1'b0;
        card_rst_n  = 1'b0;
        bus_float   = 1'b1;
        unique case (state_q)
            ST_EMPTY: ;
            ST_AWAIT_INIT: begin
                flag_nodisk = 1'b0;
                sock_pwr_en = 1'b1;
                card_rst_n  = 1'b1;
                bus_float   = 1'b0;
            end
            ST_READY: begin
                flag_nodisk = 1'b0;
                flag_noinit = 1'b0;
                sock_pwr_en = 1'b1;
                card_rst_n  = 1'b1;
                bus_float   = 1'b0;
            end
            default: ;
        endcase
    end

    AST_REMOVE_SAFES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_empty |=> (flag_nodisk && flag_noinit && !sock_pwr_en && !card_rst_n && bus_float)); // R3
    AST_INIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_noinit) |-> ($past(init_done) && !$past(flag_nodisk))); // R6
    AST_PRESENT_KEEPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_present && !init_done) |=> (!flag_nodisk && $stable(flag_noinit))); // R4
endmodule

// File: rtl/sock_timer.sv
module sock_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [TMR_W-1:0] value,
    output logic [TMR_W-1:0] count,
    output logic             zero
);
    localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   count <= '0;
        else if (load)                count <= value;
        else if (tick && count != '0) count <= count - ONE;
    end

    assign zero = (count == '0);

    AST_TMR_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == '0) |=> (count == '0)); // R5
    AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && count != '0) |=> (count == $past(count) - ONE)); // R5
    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(value))); // R8
endmodule

// File: rtl/sock_supervisor.sv
module sock_supervisor #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cd_a_n,
    input  logic             cd_b_n,
    input  logic             init_done,
    input  logic             tmr_load,
    input  logic [TMR_W-1:0] tmr_value,
    output logic             flag_nodisk,
    output logic             flag_noinit,
    output logic             sock_pwr_en,
    output logic             card_rst_n,
    output logic             bus_float,
    output logic [TMR_W-1:0] tmr_count,
    output logic             tmr_zero
);
    localparam int CD_W = 2;

    logic [CD_W-1:0] cd_bus;
    logic            ev_empty;
    logic            ev_present;

    assign cd_bus = {cd_a_n, cd_b_n};

    sock_debounce #(.CD_W(CD_W)) u_deb (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cd_n       (cd_bus),
        .ev_empty   (ev_empty),
        .ev_present (ev_present)
    );

    sock_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_empty    (ev_empty),
        .ev_present  (ev_present),
        .init_done   (init_done),
        .flag_nodisk (flag_nodisk),
        .flag_noinit (flag_noinit),
        .sock_pwr_en (sock_pwr_en),
        .card_rst_n  (card_rst_n),
        .bus_float   (bus_float)
    );

    sock_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (tmr_load),
        .value (tmr_value),
        .count (tmr_count),
        .zero  (tmr_zero)
    );
endmodule

// File: tb/sock_supervisor_tb.sv
`timescale 1ns/1ps
module sock_supervisor_tb;
    localparam int TMR_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, cd_a_n = 1'b1, cd_b_n = 1'b1, init_done = 1'b0;
    logic tmr_load = 1'b0;
    logic [TMR_W-1:0] tmr_value = '0;
    logic flag_nodisk, flag_noinit, sock_pwr_en, card_rst_n, bus_float, tmr_zero;
    logic [TMR_W-1:0] tmr_count;

    always #2.5 clk = ~clk;

    sock_supervisor #(.TMR_W(TMR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cd_a_n(cd_a_n), .cd_b_n(cd_b_n),
        .init_done(init_done), .tmr_load(tmr_load), .tmr_value(tmr_value),
        .flag_nodisk(flag_nodisk), .flag_noinit(flag_noinit), .sock_pwr_en(sock_pwr_en),
        .card_rst_n(card_rst_n), .bus_float(bus_float), .tmr_count(tmr_count),
        .tmr_zero(tmr_zero)
    );

    typedef struct {
        string            req;
        logic [4:0]       flags;
        logic [TMR_W-1:0] tval;
        logic             tz;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // flags order: nodisk, noinit, pwr_en, rst_n, float
    localparam logic [4:0] F_EMPTY = 5'b11001;
    localparam logic [4:0] F_WAIT  = 5'b01110;
    localparam logic [4:0] F_READY = 5'b00110;

    task automatic push_exp(input string req, input logic [4:0] f, input logic [TMR_W-1:0] t);
        exp_t e;
        e.req = req; e.flags = f; e.tval = t; e.tz = (t == '0);
        q.push_back(e);
    endtask

    // monitor: compares after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e = q.pop_front();
                act = {flag_nodisk, flag_noinit, sock_pwr_en, card_rst_n, bus_float};
                checks++;
                if (act !== e.flags || tmr_count !== e.tval || tmr_zero !== e.tz) begin
                    errors++;
                    $display("FAIL %s: flags=%b tmr=%0d zero=%b expected flags=%b tmr=%0d zero=%b",
                             e.req, act, tmr_count, tmr_zero, e.flags, e.tval, e.tz);
                end
            end
        end
    end

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_init();
        @(negedge clk); init_done = 1'b1;
        @(negedge clk); init_done = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_cd(input logic a, input logic b);
        @(negedge clk); cd_a_n = a; cd_b_n = b;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R7 reset state", F_EMPTY, 0);

        // insertion: first tick not enough
        set_cd(0, 0);
        do_tick();
        push_exp("R1 single sample ignored", F_EMPTY, 0);
        do_tick();
        push_exp("R4 insert clears nodisk only", F_WAIT, 0);

        pulse_init();
        push_exp("R6 init accepted with card", F_READY, 0);

        // bounce: no two equal consecutive samples
        set_cd(0, 1);
        do_tick();
        push_exp("R1 bounce sample ignored", F_READY, 0);
        set_cd(0, 0);
        do_tick();
        push_exp("R1 bounce back ignored", F_READY, 0);
        do_tick();
        push_exp("R4 present keeps noinit clear", F_READY, 0);

        // removal via line A high
        set_cd(1, 0);
        do_tick();
        do_tick();
        push_exp("R2 R3 one line high empties", F_EMPTY, 0);

        pulse_init();
        push_exp("R6 init ignored while empty", F_EMPTY, 0);

        // reinsertion, then removal racing init_done
        set_cd(0, 0);
        do_tick();
        do_tick();
        push_exp("R4 reinsert", F_WAIT, 0);
        set_cd(1, 1);
        do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0; init_done = 1'b1;
        @(negedge clk); init_done = 1'b0;
        @(negedge clk);
        push_exp("R9 removal beats init", F_EMPTY, 0);

        // timer
        @(negedge clk); tmr_load = 1'b1; tmr_value = 8'd3;
        @(negedge clk); tmr_load = 1'b0;
        push_exp("R8 load value", F_EMPTY, 3);
        do_tick();
        push_exp("R5 decrement", F_EMPTY, 2);
        do_tick();
        do_tick();
        push_exp("R5 reaches zero", F_EMPTY, 0);
        do_tick();
        push_exp("R5 holds at zero", F_EMPTY, 0);
        @(negedge clk); tmr_load = 1'b1; tmr_value = 8'd9; tick = 1'b1;
        @(negedge clk); tmr_load = 1'b0; tick = 1'b0;
        push_exp("R8 load beats tick", F_EMPTY, 9);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule